// File: doc/BRIEF.md
# Three-Phase Block FIR Filter with Reduced Sub-Filter Count

This block is a fixed-coefficient FIR filter that handles three consecutive input samples per transfer and returns three output samples per transfer. The input stream is split into three phases. Phase p of block k carries sample x[3k+p], so phase 0 is the earliest sample of the block. The TAPS coefficients are split the same way into three interleaved sets, and each set is one third as long as the filter.

A direct three-phase filter would need nine such short filters. This block uses six. Three adders combine the input phases into pair sums and a triple sum. Six short sub-filters run at the block rate and see the single phases and the combined phases. Their coefficients are the matching single or summed coefficient sets. Seven post adders and two one-block delay registers then rebuild the three output phases. The result equals the direct convolution exactly, at full precision.

Input and output use valid/ready handshakes. A transfer takes place on a clock edge where valid and ready are both high. The single output register takes new data while it is empty or while its contents are being taken in the same cycle. So `s_ready` falls only when the output holds data and the consumer holds `m_ready` low. Filter history moves forward only on an accepted input block. Idle cycles and stalls leave it untouched.

Top module: `pfir3_fast`

## Requirements
- R1: `s_ready` is high exactly when `m_valid` is low or `m_ready` is high. An input block is accepted on a rising clock edge with `s_valid` and `s_ready` both high.
- R2: For the accepted block k, output phase p equals y[3k+p] = sum over i of h[i]*x[3k+p-i]. Here x[n] counts samples accepted since reset, and any sample before the first one is taken as zero. The sum is exact, in two's complement, OUT_W = DATA_W+COEF_W+clog2(TAPS) bits wide.
- R3: The outputs for an accepted block appear with `m_valid` high in the cycle after the accepting edge.
- R4: While `m_valid` is high and `m_ready` is low, `m_data` and `m_valid` hold their values and no input block is accepted.
- R5: When the output is taken (`m_valid` and `m_ready` high) and no input is accepted on that edge, `m_valid` is low in the next cycle.
- R6: Cycles with no accepted input leave the filter history unchanged. The output for the next accepted block is the same as if the idle cycles had not happened.
- R7: An active-low reset `rst_n` clears `m_valid` and all history to zero. Right after reset, `s_ready` is high and the filter behaves as if no sample had been seen.
- R8: The lanes are packed with lane p at bits [p*DATA_W +: DATA_W] of `s_data` and at bits [p*OUT_W +: OUT_W] of `m_data`. Lane 0 holds the earliest sample of the block. Coefficient h[i] sits at bits [i*COEF_W +: COEF_W] of COEFS.
- R9: With full-scale inputs (-2^(DATA_W-1) and 2^(DATA_W-1)-1) and the default coefficients, including -128, every output is still exact, with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input block valid |
| s_ready | output | 1 | Block can accept an input block |
| s_data | input | 3*DATA_W | Three signed input samples, lane 0 earliest |
| m_valid | output | 1 | Output block valid |
| m_ready | input | 1 | Consumer accepts the output block |
| m_data | output | 3*OUT_W | Three signed output samples, lane 0 earliest |

## Verification
The bench runs random-looking and impulse blocks and compares every lane with a serial convolution model. An impulse placed in phase 0 and then in phase 1 shows whether the one-block delays or the lane packing are misplaced. A wrong sign on a delayed term, or a delay register that loads on every cycle, would corrupt the lane 0 and lane 1 results of the following block. The bench inserts idle gaps and a stretch of held-off output between blocks. A design that advanced its history or changed its output without an accepted transfer would then drift away from the model. A mid-stream reset, followed by full-scale blocks that use the most negative coefficient, catches leftover history and intermediate sums that are too narrow.

// File: rtl/pfir3_pkg.sv
package pfir3_pkg;
  localparam int NUM_PHASE = 3;
  localparam int NUM_SUB   = 6;

  // sub-filter slots: single phases, pair sums, triple sum
  typedef enum int {
    SUB_A   = 0,
    SUB_B   = 1,
    SUB_C   = 2,
    SUB_AB  = 3,
    SUB_BC  = 4,
    SUB_ABC = 5
  } sub_slot_e;
endpackage

// File: rtl/pfir3_presum.sv
module pfir3_presum
  import pfir3_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IW = DATA_W + 2
) (
  input  logic signed [DATA_W-1:0] ph_i [NUM_PHASE],
  output logic signed [IW-1:0]     sub_in_o [NUM_SUB]
);
  logic signed [IW-1:0] a_w, b_w, c_w, ab_w;

  assign a_w  = IW'(ph_i[0]);
  assign b_w  = IW'(ph_i[1]);
  assign c_w  = IW'(ph_i[2]);
  assign ab_w = a_w + b_w;

  always_comb begin
    sub_in_o[SUB_A]   = a_w;
    sub_in_o[SUB_B]   = b_w;
    sub_in_o[SUB_C]   = c_w;
    sub_in_o[SUB_AB]  = ab_w;
    sub_in_o[SUB_BC]  = b_w + c_w;
    sub_in_o[SUB_ABC] = ab_w + c_w;
  end
endmodule

// File: rtl/pfir3_subfir.sv
module pfir3_subfir #(
  parameter int IW  = 10,
  parameter int CW  = 10,
  parameter int LEN = 3,
  parameter int AW  = 26
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [IW-1:0] x_i,
  input  logic signed [CW-1:0] coef_i [LEN],
  output logic signed [AW-1:0] y_o
);
  localparam int PW = IW + CW;

  logic signed [IW-1:0] hist [LEN-1];
  logic signed [IW-1:0] tap  [LEN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < LEN - 1; j++) hist[j] <= '0;
    end else if (en) begin
      hist[0] <= x_i;
      for (int j = 1; j < LEN - 1; j++) hist[j] <= hist[j-1];
    end
  end

  always_comb begin
    tap[0] = x_i;
    for (int j = 1; j < LEN; j++) tap[j] = hist[j-1];
  end

  always_comb begin
    logic signed [PW-1:0] prod;
    y_o = '0;
    for (int j = 0; j < LEN; j++) begin
      prod = tap[j] * coef_i[j];
      y_o  = y_o + AW'(prod);
    end
  end
endmodule

// File: rtl/pfir3_post.sv
module pfir3_post
  import pfir3_pkg::*;
#(
  parameter int AW    = 26,
  parameter int OUT_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [AW-1:0]    p_i [NUM_SUB],
  output logic signed [OUT_W-1:0] y_o [NUM_PHASE]
);
  logic signed [AW-1:0] dly_c, dly_bc;
  logic signed [AW-1:0] ab_x, bc_x, lo_x;
  logic signed [AW-1:0] y0_w, y1_w, y2_w;

  // cross terms with the shared middle product removed
  assign ab_x = p_i[SUB_AB] - p_i[SUB_B];
  assign bc_x = p_i[SUB_BC] - p_i[SUB_B];
  assign lo_x = p_i[SUB_A]  - dly_c;

  assign y0_w = lo_x + dly_bc;
  assign y1_w = ab_x - lo_x;
  assign y2_w = p_i[SUB_ABC] - ab_x - bc_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_c  <= '0;
      dly_bc <= '0;
    end else if (en) begin
      dly_c  <= p_i[SUB_C];
      dly_bc <= bc_x;
    end
  end

  assign y_o[0] = y0_w[OUT_W-1:0];
  assign y_o[1] = y1_w[OUT_W-1:0];
  assign y_o[2] = y2_w[OUT_W-1:0];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (y0_w == AW'(y_o[0])) && (y1_w == AW'(y_o[1])) && (y2_w == AW'(y_o[2])))
    else $error("output exceeds OUT_W"); // R9
endmodule

// File: rtl/pfir3_fast.sv
module pfir3_fast
  import pfir3_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int TAPS   = 9,
  parameter logic [TAPS*COEF_W-1:0] COEFS = 72'h05_F7_40_FF_19_80_0C_F9_03,
  localparam int OUT_W = DATA_W + COEF_W + $clog2(TAPS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic [3*DATA_W-1:0]    s_data,
  output logic                   m_valid,
  input  logic                   m_ready,
  output logic [3*OUT_W-1:0]     m_data
);
  localparam int SUB_LEN = TAPS / NUM_PHASE;
  localparam int IW      = DATA_W + 2;
  localparam int CW      = COEF_W + 2;
  localparam int AW      = IW + CW + $clog2(SUB_LEN) + 2;

  logic                     take;
  logic signed [DATA_W-1:0] ph_w     [NUM_PHASE];
  logic signed [IW-1:0]     sub_in_w [NUM_SUB];
  logic signed [CW-1:0]     cf_w     [NUM_SUB][SUB_LEN];
  logic signed [AW-1:0]     sub_out_w[NUM_SUB];
  logic signed [OUT_W-1:0]  y_w      [NUM_PHASE];

  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;

  always_comb begin
    for (int p = 0; p < NUM_PHASE; p++) ph_w[p] = s_data[p*DATA_W +: DATA_W];
  end

  // coefficient sets per sub-filter, folded to constants
  always_comb begin
    logic signed [CW-1:0] ha, hb, hc;
    for (int j = 0; j < SUB_LEN; j++) begin
      ha = CW'($signed(COEFS[(3*j)*COEF_W   +: COEF_W]));
      hb = CW'($signed(COEFS[(3*j+1)*COEF_W +: COEF_W]));
      hc = CW'($signed(COEFS[(3*j+2)*COEF_W +: COEF_W]));
      cf_w[SUB_A][j]   = ha;
      cf_w[SUB_B][j]   = hb;
      cf_w[SUB_C][j]   = hc;
      cf_w[SUB_AB][j]  = ha + hb;
      cf_w[SUB_BC][j]  = hb + hc;
      cf_w[SUB_ABC][j] = ha + hb + hc;
    end
  end

  pfir3_presum #(.DATA_W(DATA_W)) u_presum (
    .ph_i     (ph_w),
    .sub_in_o (sub_in_w)
  );

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
    pfir3_subfir #(.IW(IW), .CW(CW), .LEN(SUB_LEN), .AW(AW)) u_sub (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (take),
      .x_i    (sub_in_w[s]),
      .coef_i (cf_w[s]),
      .y_o    (sub_out_w[s])
    );
  end

  pfir3_post #(.AW(AW), .OUT_W(OUT_W)) u_post (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (take),
    .p_i   (sub_out_w),
    .y_o   (y_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (take) begin
      m_valid <= 1'b1;
      for (int p = 0; p < NUM_PHASE; p++) m_data[p*OUT_W +: OUT_W] <= y_w[p];
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> m_valid)
    else $error("no output after accept"); // R3
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)))
    else $error("output changed under back-pressure"); // R4
  AST_NO_TAKE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready)
    else $error("ready while stalled"); // R1
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && !s_valid) |=> !m_valid)
    else $error("valid stuck after drain"); // R5
endmodule

// File: tb/pfir3_fast_tb_top.sv
module pfir3_fast_tb_top;
  localparam int DATA_W = 8;
  localparam int COEF_W = 8;
  localparam int TAPS   = 9;
  localparam logic [TAPS*COEF_W-1:0] COEFS = 72'h05_F7_40_FF_19_80_0C_F9_03;
  localparam int OUT_W  = DATA_W + COEF_W + $clog2(TAPS);
  localparam int NSTIM  = 12;
  localparam int STIM [NSTIM][3] = '{
    '{ 17, -3, 99}, '{-45, 12, 7}, '{ 0, 0, 1}, '{ 88, -90, 23},
    '{-1, -1, -1}, '{ 64, 32, -16}, '{ 5, -77, 120}, '{-128, 3, 44},
    '{ 9, 9, -9}, '{-60, 101, -2}, '{ 33, -33, 66}, '{ 127, -128, 0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [3*DATA_W-1:0] s_data = '0;
  logic m_valid;
  logic m_ready = 1'b1;
  logic [3*OUT_W-1:0] m_data;

  int checks = 0;
  int bad = 0;
  int xs [4096];
  int nx = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pfir3_fast #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS), .COEFS(COEFS)) dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  function automatic int h_tap(int i);
    if (i < 0 || i >= TAPS) return 0;
    return int'($signed(COEFS[i*COEF_W +: COEF_W]));
  endfunction

  function automatic int ref_y(int n);
    int acc = 0;
    for (int i = 0; i < TAPS; i++) if (n - i >= 0) acc += h_tap(i) * xs[n-i];
    return acc;
  endfunction

  function automatic int lane(int p);
    return int'($signed(m_data[p*OUT_W +: OUT_W]));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_lanes(string req);
    chk({req, " valid"}, int'(m_valid), 1);
    for (int p = 0; p < 3; p++) chk(req, lane(p), ref_y(nx - 3 + p));
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic push_blk(int a, int b, int c, string req);
    s_valid = 1'b1;
    s_data  = {DATA_W'(c), DATA_W'(b), DATA_W'(a)};
    @(posedge clk);
    xs[nx] = a; xs[nx+1] = b; xs[nx+2] = c; nx += 3;
    @(negedge clk);
    s_valid = 1'b0;
    chk_lanes(req);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int hold [3];
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7 m_valid in reset", int'(m_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 s_ready after reset", int'(s_ready), 1);
    chk("R7 m_valid after reset", int'(m_valid), 0);

    // R2 / R3 table walk, back-to-back blocks
    for (int k = 0; k < NSTIM; k++) push_blk(STIM[k][0], STIM[k][1], STIM[k][2], "R2 table");

    // R5 drain with no new input
    @(negedge clk);
    chk("R5 m_valid after drain", int'(m_valid), 0);

    // R6 idle gaps do not advance history
    push_blk(40, -20, 10, "R6 before gap");
    repeat (5) @(negedge clk);
    push_blk(-7, 55, -99, "R6 after gap");

    // R4 / R1 back-pressure
    @(negedge clk);
    m_ready = 1'b0;
    push_blk(11, 22, 33, "R4 first held block");
    for (int p = 0; p < 3; p++) hold[p] = ref_y(nx - 3 + p);
    s_valid = 1'b1;
    s_data  = {DATA_W'(-5), DATA_W'(6), DATA_W'(-7)};
    chk("R1 s_ready low when stalled", int'(s_ready), 0);
    repeat (3) @(negedge clk);
    chk("R4 valid held", int'(m_valid), 1);
    for (int p = 0; p < 3; p++) chk("R4 data held", lane(p), hold[p]);
    m_ready = 1'b1;
    #1;
    chk("R1 s_ready with consumer ready", int'(s_ready), 1);
    @(posedge clk);
    xs[nx] = -7; xs[nx+1] = 6; xs[nx+2] = -5; nx += 3;
    @(negedge clk);
    s_valid = 1'b0;
    chk_lanes("R4 block after release");

    // R7 mid-stream reset clears history
    rst_n = 1'b0;
    @(negedge clk);
    chk("R7 m_valid after mid reset", int'(m_valid), 0);
    chk("R7 s_ready in mid reset", int'(s_ready), 1);
    rst_n = 1'b1;
    nx = 0;
    @(negedge clk);
    push_blk(1, 0, 0, "R7 impulse after reset");
    for (int p = 0; p < 3; p++) chk("R2 impulse block0", lane(p), h_tap(p));
    push_blk(0, 0, 0, "R2 impulse tail");
    for (int p = 0; p < 3; p++) chk("R2 impulse block1", lane(p), h_tap(3 + p));
    push_blk(0, 0, 0, "R2 impulse tail");
    for (int p = 0; p < 3; p++) chk("R2 impulse block2", lane(p), h_tap(6 + p));
    push_blk(0, 0, 0, "R2 impulse end");

    // R8 lane packing: impulse in phase 1
    push_blk(0, 1, 0, "R8 phase1 impulse");
    chk("R8 lane0", lane(0), 0);
    chk("R8 lane1", lane(1), h_tap(0));
    chk("R8 lane2", lane(2), h_tap(1));
    push_blk(0, 0, 0, "R8 phase1 tail");
    chk("R8 next lane0", lane(0), h_tap(2));

    // R9 full-scale inputs
    for (int k = 0; k < 4; k++) push_blk(-128, -128, -128, "R9 negative full scale");
    for (int k = 0; k < 4; k++) push_blk(127, 127, 127, "R9 positive full scale");
    for (int k = 0; k < 4; k++) push_blk(-128, 127, -128, "R9 alternating");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule